// File: doc/BRIEF.md
# Pin Event Detector with Selectable Glitch Filter

This block watches a bank of asynchronous general-purpose pins and turns their level changes into interrupt events. Each pin first passes through a two-flop synchroniser. The synchronised level goes straight to the peripheral-facing output and to the pin-value read register. It also feeds an optional per-pin glitch filter. A new level passes the filter only after it has been sampled on two consecutive clock edges. The filter output, or the raw synchronised level when the filter is off, drives an edge detector.

The edge detector works in one of four modes per pin. A detected event sets a sticky flag. Software clears a flag by writing a 1 to its bit. A per-pin mask selects which flags drive the single interrupt request line. A small register port handles configuration: a write strobe with address and data, and a combinational read selected by a separate read address.

Top module: `pin_event_filter`

## Requirements
- R1: After reset all flags, filter enables and interrupt masks are 0, every pin's edge mode reads as 2'b11 (no events), and `irq` is 0.
- R2: `pinLevel` and the pin-value register (read address 5) show each pin delayed by two clock edges: a level applied before edge 1 appears just after edge 2.
- R3: With a pin's filter on, a pulse that is high at only one rising edge never sets its flag.
- R4: With a pin's filter on, a pulse held high across two consecutive rising edges sets its flag.
- R5: The filter adds exactly two cycles. An unfiltered rising level sets the flag just after edge 3, and a filtered one sets it just after edge 5.
- R6: The filter has no effect on `pinLevel` or the pin-value register. Both follow the synchronised level while the filter is on.
- R7: With the filter off, a pulse that is high at a single rising edge sets its flag.
- R8: The edge mode is 2 bits per pin: 00 any change, 01 rising, 10 falling, 11 none. Pin p, for p < 16, sits at bits [2p+1:2p] of address 2. Pin p, for p >= 16, sits at bits [2(p-16)+1:2(p-16)] of address 3.
- R9: Flags (read address 4) stay set until a 1 is written to the matching bit at address 4. Writing 1 clears the flag and writing 0 leaves it unchanged.
- R10: If a clear and a new event for the same pin fall in the same cycle, the flag ends set.
- R11: `irq` is high exactly when some flag is set whose bit is 1 in the mask register (address 1).
- R12: Address 0 holds the per-pin filter enables, where 1 turns filtering on. Addresses 0 to 3 read back the value last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | NPINS | Raw asynchronous pin levels |
| pinLevel | output | NPINS | Synchronised, unfiltered pin levels for peripherals |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 32 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 32 | Combinational read data |
| irq | output | 1 | Masked OR of the sticky event flags |

## Verification
Several rules are checked on every cycle by assertions. A flag never drops unless its clear bit was written. An event always leaves its flag set, even when a clear arrives in the same cycle. A filtered level changes only after the synchronised level has held for two samples. A pin in mode 11 never gains a flag. The exact latencies and the pass or reject boundary of the filter can only be shown by the bench. It drives pulses of set widths and checks the cycle in which each flag appears. The same holds for unfiltered readback while filtering is on, and for mode selection and mask gating. A behavioural model running alongside compares flags, pin levels and `irq` on every clock.

// File: rtl/pef_pkg.sv
package pef_pkg;

  localparam logic [2:0] ADR_FILT    = 3'd0;
  localparam logic [2:0] ADR_MASK    = 3'd1;
  localparam logic [2:0] ADR_MODE_LO = 3'd2;
  localparam logic [2:0] ADR_MODE_HI = 3'd3;
  localparam logic [2:0] ADR_FLAGS   = 3'd4;
  localparam logic [2:0] ADR_PINS    = 3'd5;

  typedef enum logic [1:0] {
    EDGE_ANY  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_OFF  = 2'b11
  } edgeMode_t;

  typedef struct packed {
    logic wrFilt;
    logic wrMask;
    logic wrModeLo;
    logic wrModeHi;
    logic clrFlags;
  } ctlStrobes_t;

endpackage

// File: rtl/pef_sync.sv
module pef_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= din;
      stage2 <= stage1;
    end
  end

  assign dout = stage2;

endmodule

// File: rtl/pef_ctrl.sv
module pef_ctrl
  import pef_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int DW    = 32
) (
  input  logic               wrEn,
  input  logic [2:0]         wrAddr,
  input  logic [2:0]         rdAddr,
  input  logic [NPINS-1:0]   filtEn,
  input  logic [NPINS-1:0]   irqMask,
  input  logic [2*NPINS-1:0] modeVec,
  input  logic [NPINS-1:0]   flags,
  input  logic [NPINS-1:0]   pinLevel,
  output ctlStrobes_t        str,
  output logic [DW-1:0]      rdData
);

  localparam int MW = 2 * DW;

  logic [MW-1:0] modeWide;
  assign modeWide = MW'(modeVec);

  always_comb begin
    str          = '0;
    str.wrFilt   = wrEn && (wrAddr == ADR_FILT);
    str.wrMask   = wrEn && (wrAddr == ADR_MASK);
    str.wrModeLo = wrEn && (wrAddr == ADR_MODE_LO);
    str.wrModeHi = wrEn && (wrAddr == ADR_MODE_HI);
    str.clrFlags = wrEn && (wrAddr == ADR_FLAGS);
  end

  always_comb begin
    case (rdAddr)
      ADR_FILT:    rdData = DW'(filtEn);
      ADR_MASK:    rdData = DW'(irqMask);
      ADR_MODE_LO: rdData = modeWide[DW-1:0];
      ADR_MODE_HI: rdData = modeWide[MW-1:DW];
      ADR_FLAGS:   rdData = DW'(flags);
      ADR_PINS:    rdData = DW'(pinLevel);
      default:     rdData = '0;
    endcase
  end

endmodule

// File: rtl/pef_datapath.sv
module pef_datapath
  import pef_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int DW    = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NPINS-1:0]   pinIn,
  input  ctlStrobes_t        str,
  input  logic [DW-1:0]      wrData,
  output logic [NPINS-1:0]   pinLevel,
  output logic [NPINS-1:0]   filtEn,
  output logic [NPINS-1:0]   irqMask,
  output logic [2*NPINS-1:0] modeVec,
  output logic [NPINS-1:0]   flags,
  output logic               irq
);

  localparam int PER_WORD = DW / 2;

  logic [NPINS-1:0] syncLvl;
  logic [NPINS-1:0] lastSample;
  logic [NPINS-1:0] filtLvl;
  logic [NPINS-1:0] detIn;
  logic [NPINS-1:0] prevDet;
  logic [NPINS-1:0] evVec;
  logic [NPINS-1:0] clrVec;
  logic [NPINS-1:0] offMask;

  pef_sync #(.W(NPINS)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (pinIn),
    .dout (syncLvl)
  );

  assign pinLevel = syncLvl;

  // Config registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtEn  <= '0;
      irqMask <= '0;
    end else begin
      if (str.wrFilt) filtEn  <= wrData[NPINS-1:0];
      if (str.wrMask) irqMask <= wrData[NPINS-1:0];
    end
  end

  // Two-sample filter: accept a level once it matched the previous sample
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastSample <= '0;
      filtLvl    <= '0;
    end else begin
      lastSample <= syncLvl;
      filtLvl    <= (filtLvl & (syncLvl ^ lastSample)) | (syncLvl & ~(syncLvl ^ lastSample));
    end
  end

  assign detIn = (filtEn & filtLvl) | (~filtEn & syncLvl);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevDet <= '0;
    else       prevDet <= detIn;
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    localparam int WSEL = p / PER_WORD;
    localparam int OFS  = 2 * (p % PER_WORD);

    edgeMode_t mode;
    logic      wrThis;
    logic      ev;

    if (WSEL == 0) begin : g_lo
      assign wrThis = str.wrModeLo;
    end else begin : g_hi
      assign wrThis = str.wrModeHi;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       mode <= EDGE_OFF;
      else if (wrThis) mode <= edgeMode_t'(wrData[OFS +: 2]);
    end

    always_comb begin
      case (mode)
        EDGE_ANY:  ev = detIn[p] ^ prevDet[p];
        EDGE_RISE: ev = detIn[p] & ~prevDet[p];
        EDGE_FALL: ev = ~detIn[p] & prevDet[p];
        default:   ev = 1'b0;
      endcase
    end

    assign evVec[p]         = ev;
    assign modeVec[2*p +: 2] = mode;
    assign offMask[p]       = (mode == EDGE_OFF);
  end

  assign clrVec = str.clrFlags ? wrData[NPINS-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= (flags & ~clrVec) | evVec;
  end

  assign irq = |(flags & irqMask);

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (($past(flags) & ~$past(clrVec) & ~flags) == '0)); // R9

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (($past(evVec) & ~flags) == '0)); // R10

  AST_FILT_TWO_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    (((filtLvl ^ $past(filtLvl)) & ($past(syncLvl) ^ $past(syncLvl, 2))) == '0)); // R3

  AST_MODE_OFF_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    ((flags & ~$past(flags) & $past(offMask)) == '0)); // R8

endmodule

// File: rtl/pin_event_filter.sv
module pin_event_filter
  import pef_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NPINS-1:0] pinIn,
  output logic [NPINS-1:0] pinLevel,
  input  logic             wrEn,
  input  logic [2:0]       wrAddr,
  input  logic [DW-1:0]    wrData,
  input  logic [2:0]       rdAddr,
  output logic [DW-1:0]    rdData,
  output logic             irq
);

  ctlStrobes_t        str;
  logic [NPINS-1:0]   filtEn;
  logic [NPINS-1:0]   irqMask;
  logic [2*NPINS-1:0] modeVec;
  logic [NPINS-1:0]   flags;

  pef_ctrl #(.NPINS(NPINS), .DW(DW)) u_ctrl (
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .rdAddr   (rdAddr),
    .filtEn   (filtEn),
    .irqMask  (irqMask),
    .modeVec  (modeVec),
    .flags    (flags),
    .pinLevel (pinLevel),
    .str      (str),
    .rdData   (rdData)
  );

  pef_datapath #(.NPINS(NPINS), .DW(DW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .pinIn    (pinIn),
    .str      (str),
    .wrData   (wrData),
    .pinLevel (pinLevel),
    .filtEn   (filtEn),
    .irqMask  (irqMask),
    .modeVec  (modeVec),
    .flags    (flags),
    .irq      (irq)
  );

endmodule

// File: tb/pin_event_filter_bench.sv
`timescale 1ns/1ps
module pin_event_filter_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] pinIn = '0;
  logic [31:0] pinLevel;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  rdAddr = 3'd2;
  logic [31:0] rdData;
  logic        irq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  pin_event_filter u_pin_event_filter (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .pinLevel(pinLevel),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [31:0] hist[$];
  logic [31:0] mFilt, mPrev, mFlags, mMask, mFen;
  logic [1:0]  mMode[32];

  always @(posedge clk) begin
    if (!rstN) begin
      hist = '{32'h0, 32'h0, 32'h0};
      mFilt = '0; mPrev = '0; mFlags = '0; mMask = '0; mFen = '0;
      for (int i = 0; i < 32; i++) mMode[i] = 2'b11;
    end else begin
      logic [31:0] det, clr, ev;
      det = (mFen & mFilt) | (~mFen & hist[1]);
      ev = '0;
      for (int i = 0; i < 32; i++) begin
        case (mMode[i])
          2'b00: ev[i] = det[i] != mPrev[i];
          2'b01: ev[i] = det[i] && !mPrev[i];
          2'b10: ev[i] = !det[i] && mPrev[i];
          default: ev[i] = 1'b0;
        endcase
        if (hist[1][i] == hist[2][i]) mFilt[i] = hist[1][i];
      end
      clr = (wrEn && wrAddr == 3'd4) ? wrData : '0;
      mFlags = (mFlags & ~clr) | ev;
      mPrev = det;
      if (wrEn && wrAddr == 3'd0) mFen = wrData;
      if (wrEn && wrAddr == 3'd1) mMask = wrData;
      if (wrEn && wrAddr == 3'd2) for (int i = 0; i < 16; i++) mMode[i] = wrData[2*i +: 2];
      if (wrEn && wrAddr == 3'd3) for (int i = 0; i < 16; i++) mMode[16+i] = wrData[2*i +: 2];
      hist.push_front(pinIn);
      void'(hist.pop_back());
      #2;
      if (!done) begin
        chk(pinLevel == hist[1], "R2 model pinLevel", pinLevel, hist[1]);
        chk(irq == |(mFlags & mMask), "R11 model irq", {31'd0, irq}, {31'd0, |(mFlags & mMask)});
        if (rdAddr == 3'd4) chk(rdData == mFlags, "R9 model flags", rdData, mFlags);
        if (rdAddr == 3'd5) chk(rdData == hist[1], "R6 model readback", rdData, hist[1]);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitE(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    waitE(1);
    // R1 reset state
    chk(rdData == 32'hFFFF_FFFF, "R1 modes off", rdData, 32'hFFFF_FFFF);
    chk(irq == 1'b0, "R1 irq", {31'd0, irq}, 32'd0);
    @(negedge clk) rdAddr = 3'd0;
    #1 chk(rdData == 32'h0, "R1 filters off", rdData, 32'h0);
    rdAddr = 3'd4;
    #1 chk(rdData == 32'h0, "R1 flags clear", rdData, 32'h0);

    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd2, 32'h5555_5555);
    wr(3'd3, 32'h5555_5555);
    @(negedge clk) rdAddr = 3'd1;
    #1 chk(rdData == 32'hFFFF_FFFF, "R12 mask readback", rdData, 32'hFFFF_FFFF);
    rdAddr = 3'd4;

    // R2 / R7 unfiltered latency
    @(negedge clk) pinIn[3] = 1'b1;
    waitE(1); chk(pinLevel[3] == 1'b0, "R2 edge1", pinLevel, 32'h0);
    waitE(1); chk(pinLevel[3] == 1'b1, "R2 edge2", pinLevel, 32'h8);
    chk(rdData[3] == 1'b0, "R5 unfiltered not yet", rdData, 32'h0);
    waitE(1); chk(rdData[3] == 1'b1, "R5 unfiltered edge3", rdData, 32'h8);
    chk(irq == 1'b1, "R11 irq on flag", {31'd0, irq}, 32'd1);
    @(negedge clk) pinIn[3] = 1'b0;
    waitE(4); chk(rdData[3] == 1'b1, "R9 sticky", rdData, 32'h8);
    wr(3'd4, 32'h0);
    chk(rdData[3] == 1'b1, "R9 write 0 no effect", rdData, 32'h8);
    wr(3'd4, 32'h8);
    chk(rdData[3] == 1'b0, "R9 w1c", rdData, 32'h0);

    // R7 single-cycle pulse unfiltered
    @(negedge clk) pinIn[5] = 1'b1;
    @(negedge clk) pinIn[5] = 1'b0;
    waitE(4); chk(rdData[5] == 1'b1, "R7 short pulse caught", rdData, 32'h20);
    wr(3'd4, 32'h20);

    // R3 / R6 filter on pins 5, 6
    wr(3'd0, 32'h60);
    @(negedge clk) rdAddr = 3'd0;
    #1 chk(rdData == 32'h60, "R12 filter readback", rdData, 32'h60);
    rdAddr = 3'd5;
    @(negedge clk) pinIn[5] = 1'b1;
    @(negedge clk) pinIn[5] = 1'b0;
    waitE(1);
    chk(pinLevel[5] == 1'b1, "R6 pinLevel unfiltered", pinLevel, 32'h20);
    chk(rdData[5] == 1'b1, "R6 readback unfiltered", rdData, 32'h20);
    @(negedge clk) rdAddr = 3'd4;
    waitE(5); chk(rdData[5] == 1'b0, "R3 pulse rejected", rdData, 32'h0);

    // R4 / R5 two-cycle pulse filtered
    @(negedge clk) pinIn[6] = 1'b1;
    @(negedge clk);
    @(negedge clk) pinIn[6] = 1'b0;
    waitE(2); chk(rdData[6] == 1'b0, "R5 filtered not at edge4", rdData, 32'h0);
    waitE(1); chk(rdData[6] == 1'b1, "R4 filtered at edge5", rdData, 32'h40);
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd0, 32'h0);

    // R8 modes: pin7 fall, pin8 any, pin9 off
    wr(3'd2, 32'h555C_9555);
    @(negedge clk) pinIn[7] = 1'b1;
    waitE(5); chk(rdData[7] == 1'b0, "R8 fall ignores rise", rdData, 32'h0);
    @(negedge clk) pinIn[7] = 1'b0;
    waitE(3); chk(rdData[7] == 1'b1, "R8 fall detected", rdData, 32'h80);
    @(negedge clk) pinIn[8] = 1'b1;
    waitE(3); chk(rdData[8] == 1'b1, "R8 any rise", rdData, 32'h100);
    wr(3'd4, 32'h100);
    @(negedge clk) pinIn[8] = 1'b0;
    waitE(3); chk(rdData[8] == 1'b1, "R8 any fall", rdData, 32'h100);
    @(negedge clk) pinIn[9] = 1'b1;
    waitE(3);
    @(negedge clk) pinIn[9] = 1'b0;
    waitE(4); chk(rdData[9] == 1'b0, "R8 off mode silent", rdData, 32'h0);
    wr(3'd4, 32'hFFFF_FFFF);

    // R10 clear and event in the same cycle
    @(negedge clk) pinIn[10] = 1'b1;
    @(negedge clk);
    @(negedge clk) begin wrEn = 1'b1; wrAddr = 3'd4; wrData = 32'h400; end
    @(negedge clk) wrEn = 1'b0;
    chk(rdData[10] == 1'b1, "R10 event beats clear", rdData, 32'h400);
    wr(3'd4, 32'hFFFF_FFFF);

    // R11 mask gating
    wr(3'd1, 32'h800);
    @(negedge clk) pinIn[12] = 1'b1;
    waitE(3);
    chk(rdData[12] == 1'b1, "R11 flag set unmasked", rdData, 32'h1000);
    chk(irq == 1'b0, "R11 masked no irq", {31'd0, irq}, 32'd0);
    @(negedge clk) pinIn[11] = 1'b1;
    waitE(3); chk(irq == 1'b1, "R11 enabled irq", {31'd0, irq}, 32'd1);

    waitE(2);
    finishRun();
  end

endmodule